// File: doc/BRIEF.md
# Tagged Register and Memory Taint Tracker

This block runs a stream of simple micro-operations over a small register file and a small data memory, where every register and every memory word carries one extra tag bit that marks the value as untrusted. The tag is written together with the data and moves with it on every load, store and ALU operation. Values brought in through the user-input micro-op are tagged automatically. A compare clears the tag of the register it examines, which models a sanity check on input.

The block checks tags when a register is used as a pointer. A load, store or indirect jump whose address register is tagged is refused. The block then pulses a fault output for one cycle and reports which register held the bad address. No register or memory word changes for that operation. Each accepted operation completes in one cycle. On the edge that follows, its result appears on registered outputs: either the result value with its tag, or the fault.

Top module: `taint_unit`

## Requirements
- R1: Reset clears all 8 registers and all 64 memory words to value 0 with tag 0, and holds res_valid and fault low.
- R2: INPUT (op_code 0) writes op_imm into register op_rd with tag 1; the next cycle shows res_valid=1, res_data=op_imm, res_tag=1.
- R3: CONST (op_code 1) writes op_imm into op_rd with tag 0, and reports it the same way with res_tag=0.
- R4: ALU (op_code 2) writes op_rd with f(rs1,rs2), where op_fn 0=add, 1=subtract (rs1-rs2), 2=xor, 3=pass rs1, all modulo 2^16. The result tag is the OR of the two source tags.
- R5: LOAD (op_code 4) reads the memory word at the low 6 bits of register op_rs1 into op_rd together with that word's tag, and reports that value and tag.
- R6: STORE (op_code 5) writes register op_rs2's value and tag into the memory word at the low 6 bits of op_rs1, and reports the stored value and tag.
- R7: A load or store whose address register is untagged completes normally whatever the tag of the data it moves.
- R8: A LOAD, STORE or JUMP whose op_rs1 register is tagged changes no register or memory word. On the next cycle fault=1 with fault_reg=op_rs1 and res_valid=0, and fault lasts one cycle for each such operation.
- R9: COMPARE (op_code 3) reports res_data=1 when registers rs1 and rs2 are equal and 0 otherwise, with res_tag=0. It clears the tag of rs1 and leaves every value and the tag of rs2 unchanged (unless rs2 is the same register).
- R10: JUMP (op_code 6) with an untagged rs1 reports res_data = the full 16-bit value of rs1 as the target, with res_tag=0, and changes no state.
- R11: op_code 7 is reserved: it changes no state and raises neither res_valid nor fault.
- R12: op_ready is high whenever reset is low. A cycle with op_valid low changes no state and raises neither res_valid nor fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Micro-op present |
| op_ready | output | 1 | Block can accept a micro-op |
| op_code | input | 3 | Micro-op kind (0 input, 1 const, 2 alu, 3 compare, 4 load, 5 store, 6 jump, 7 reserved) |
| op_fn | input | 2 | ALU function select |
| op_rd | input | 3 | Destination register index |
| op_rs1 | input | 3 | First source, address or jump register index |
| op_rs2 | input | 3 | Second source or store data register index |
| op_imm | input | 16 | Immediate or user-input value |
| res_valid | output | 1 | Result of the previous accepted micro-op is valid |
| res_data | output | 16 | Result value |
| res_tag | output | 1 | Taint tag of the result |
| fault | output | 1 | Tainted address use, one-cycle pulse |
| fault_reg | output | 3 | Register index that held the tainted address |

## Verification
The hardest case to reach is a tainted value that has travelled through memory and the ALU before it is used as a pointer. A user-input value must be stored through a clean pointer, loaded back and combined in the ALU. The result is then used as an address. After that, a compare must clean the register, so that the same pointer now works. Directed sequences build these chains explicitly, including back-to-back faults and a compare of a register with itself. A long seeded random run then mixes all micro-op kinds so that tags spread and clear in orders that no directed case lists. A final sweep over every memory word checks that no faulting store left a trace.

// File: rtl/taint_pkg.sv
package taint_pkg;

    parameter int DATA_W    = 16;
    parameter int REG_COUNT = 8;
    parameter int MEM_DEPTH = 64;

    localparam int REG_IW = $clog2(REG_COUNT);
    localparam int MEM_AW = $clog2(MEM_DEPTH);

    typedef enum logic [2:0] {
        UOP_INPUT = 3'd0,
        UOP_CONST = 3'd1,
        UOP_ALU   = 3'd2,
        UOP_CMP   = 3'd3,
        UOP_LOAD  = 3'd4,
        UOP_STORE = 3'd5,
        UOP_JUMP  = 3'd6,
        UOP_RSVD  = 3'd7
    } uop_code_e;

    typedef enum logic [1:0] {
        FN_ADD  = 2'd0,
        FN_SUB  = 2'd1,
        FN_XOR  = 2'd2,
        FN_PASS = 2'd3
    } alu_fn_e;

    // A data word together with its taint tag
    typedef struct packed {
        logic              tag;
        logic [DATA_W-1:0] val;
    } tword_t;

    typedef struct packed {
        uop_code_e         code;
        alu_fn_e           fn;
        logic [REG_IW-1:0] rd;
        logic [REG_IW-1:0] rs1;
        logic [REG_IW-1:0] rs2;
        logic [DATA_W-1:0] imm;
    } uop_t;

    function automatic logic [DATA_W-1:0] alu_eval(alu_fn_e fn,
                                                   logic [DATA_W-1:0] a,
                                                   logic [DATA_W-1:0] b);
        unique case (fn)
            FN_ADD:  return a + b;
            FN_SUB:  return a - b;
            FN_XOR:  return a ^ b;
            default: return a;
        endcase
    endfunction

    // Micro-ops that treat rs1 as a pointer
    function automatic logic uses_pointer(uop_code_e c);
        return (c == UOP_LOAD) || (c == UOP_STORE) || (c == UOP_JUMP);
    endfunction

endpackage

// File: rtl/taint_regfile.sv
module taint_regfile
    import taint_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_IW-1:0] rd_a_idx,
    output tword_t            rd_a,
    input  logic [REG_IW-1:0] rd_b_idx,
    output tword_t            rd_b,
    input  logic              we,
    input  logic [REG_IW-1:0] wr_idx,
    input  tword_t            wr_word
);

    tword_t regs [REG_COUNT];

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && (wr_idx == REG_IW'(g))) begin
                regs[g] <= wr_word;
            end
        end
    end

    assign rd_a = regs[rd_a_idx];
    assign rd_b = regs[rd_b_idx];

endmodule

// File: rtl/taint_dmem.sv
module taint_dmem
    import taint_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MEM_AW-1:0] addr,
    output tword_t            rdata,
    input  logic              we,
    input  tword_t            wdata
);

    tword_t words [MEM_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_DEPTH; i++) begin
                words[i] <= '0;
            end
        end else if (we) begin
            words[addr] <= wdata;
        end
    end

    assign rdata = words[addr];

endmodule

// File: rtl/taint_exec.sv
module taint_exec
    import taint_pkg::*;
(
    input  logic              fire,
    input  uop_t              uop,
    input  tword_t            src_a,
    input  tword_t            src_b,
    input  tword_t            mem_rd,
    output logic              rf_we,
    output logic [REG_IW-1:0] rf_widx,
    output tword_t            rf_wword,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output tword_t            mem_wword,
    output logic              res_ok,
    output tword_t            res_word,
    output logic              trap,
    output logic [REG_IW-1:0] trap_reg
);

    logic pointer_bad;

    assign pointer_bad = uses_pointer(uop.code) && src_a.tag;
    assign trap        = fire && pointer_bad;
    assign trap_reg    = uop.rs1;
    assign mem_addr    = src_a.val[MEM_AW-1:0];

    always_comb begin
        rf_we     = 1'b0;
        rf_widx   = uop.rd;
        rf_wword  = '0;
        mem_we    = 1'b0;
        mem_wword = src_b;
        res_word  = '0;
        res_ok    = fire && !pointer_bad && (uop.code != UOP_RSVD);

        unique case (uop.code)
            UOP_INPUT: begin
                rf_wword = '{tag: 1'b1, val: uop.imm};
                rf_we    = fire;
            end
            UOP_CONST: begin
                rf_wword = '{tag: 1'b0, val: uop.imm};
                rf_we    = fire;
            end
            UOP_ALU: begin
                rf_wword = '{tag: src_a.tag | src_b.tag,
                             val: alu_eval(uop.fn, src_a.val, src_b.val)};
                rf_we    = fire;
            end
            UOP_CMP: begin
                // value kept, tag of the checked register dropped
                rf_widx  = uop.rs1;
                rf_wword = '{tag: 1'b0, val: src_a.val};
                rf_we    = fire;
                res_word = '{tag: 1'b0,
                             val: DATA_W'(src_a.val == src_b.val)};
            end
            UOP_LOAD: begin
                rf_wword = mem_rd;
                rf_we    = fire && !pointer_bad;
            end
            UOP_STORE: begin
                mem_we   = fire && !pointer_bad;
                rf_wword = src_b;
            end
            UOP_JUMP: begin
                rf_wword = '{tag: 1'b0, val: src_a.val};
            end
            default: begin
                rf_wword = '0;
            end
        endcase

        if (uop.code != UOP_CMP) begin
            res_word = rf_wword;
        end
    end

endmodule

// File: rtl/taint_unit.sv
module taint_unit
    import taint_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [2:0]        op_code,
    input  logic [1:0]        op_fn,
    input  logic [REG_IW-1:0] op_rd,
    input  logic [REG_IW-1:0] op_rs1,
    input  logic [REG_IW-1:0] op_rs2,
    input  logic [DATA_W-1:0] op_imm,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              res_tag,
    output logic              fault,
    output logic [REG_IW-1:0] fault_reg
);

    uop_t              uop;
    logic              fire;
    tword_t            src_a, src_b, mem_rd, rf_wword, mem_wword, res_word;
    logic              rf_we, mem_we, res_ok, trap;
    logic [REG_IW-1:0] rf_widx, trap_reg;
    logic [MEM_AW-1:0] mem_addr;
    logic              src_a_tag, src_b_tag;

    assign op_ready = !rst;
    assign fire     = op_valid && op_ready;

    assign uop = '{code: uop_code_e'(op_code), fn: alu_fn_e'(op_fn),
                   rd: op_rd, rs1: op_rs1, rs2: op_rs2, imm: op_imm};

    assign src_a_tag = src_a.tag;
    assign src_b_tag = src_b.tag;

    taint_regfile u_rf (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (op_rs1),
        .rd_a     (src_a),
        .rd_b_idx (op_rs2),
        .rd_b     (src_b),
        .we       (rf_we),
        .wr_idx   (rf_widx),
        .wr_word  (rf_wword)
    );

    taint_dmem u_mem (
        .clk   (clk),
        .rst   (rst),
        .addr  (mem_addr),
        .rdata (mem_rd),
        .we    (mem_we),
        .wdata (mem_wword)
    );

    taint_exec u_exec (
        .fire      (fire),
        .uop       (uop),
        .src_a     (src_a),
        .src_b     (src_b),
        .mem_rd    (mem_rd),
        .rf_we     (rf_we),
        .rf_widx   (rf_widx),
        .rf_wword  (rf_wword),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wword (mem_wword),
        .res_ok    (res_ok),
        .res_word  (res_word),
        .trap      (trap),
        .trap_reg  (trap_reg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            res_tag   <= 1'b0;
            fault     <= 1'b0;
            fault_reg <= '0;
        end else begin
            res_valid <= res_ok;
            fault     <= trap;
            fault_reg <= trap ? trap_reg : '0;
            if (res_ok) begin
                res_data <= res_word.val;
                res_tag  <= res_word.tag;
            end
        end
    end

endmodule

// File: rtl/taint_unit_chk.sv
module taint_unit_chk
    import taint_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic              op_ready,
    input logic [2:0]        op_code,
    input logic [REG_IW-1:0] op_rs1,
    input logic [DATA_W-1:0] op_imm,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic              res_tag,
    input logic              fault,
    input logic [REG_IW-1:0] fault_reg,
    input logic              src_a_tag,
    input logic              src_b_tag
);

    logic acc;
    logic ptr_op;
    assign acc    = op_valid && op_ready;
    assign ptr_op = (op_code == 3'd4) || (op_code == 3'd5) || (op_code == 3'd6);

    AST_RESULT_OR_FAULT: assert property (@(posedge clk) disable iff (rst)
        !(fault && res_valid)); // R8

    AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        op_ready); // R12

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!res_valid && !fault)); // R12

    AST_INPUT_TAINTED: assert property (@(posedge clk) disable iff (rst)
        (acc && op_code == 3'd0) |=>
            (res_valid && res_tag && res_data == $past(op_imm))); // R2

    AST_CONST_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (acc && op_code == 3'd1) |=>
            (res_valid && !res_tag && res_data == $past(op_imm))); // R3

    AST_ALU_TAG_MERGE: assert property (@(posedge clk) disable iff (rst)
        (acc && op_code == 3'd2) |=>
            (res_valid && res_tag == ($past(src_a_tag) || $past(src_b_tag)))); // R4

    AST_CMP_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (acc && op_code == 3'd3) |=> (res_valid && !res_tag)); // R9

    AST_POINTER_TRAP: assert property (@(posedge clk) disable iff (rst)
        (acc && ptr_op && src_a_tag) |=>
            (fault && !res_valid && fault_reg == $past(op_rs1))); // R8

    AST_CLEAN_POINTER_GOES: assert property (@(posedge clk) disable iff (rst)
        (acc && ptr_op && !src_a_tag) |=> (res_valid && !fault)); // R7

    AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (acc && op_code == 3'd7) |=> (!res_valid && !fault)); // R11

endmodule

bind taint_unit taint_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_ready  (op_ready),
    .op_code   (op_code),
    .op_rs1    (op_rs1),
    .op_imm    (op_imm),
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_tag   (res_tag),
    .fault     (fault),
    .fault_reg (fault_reg),
    .src_a_tag (src_a_tag),
    .src_b_tag (src_b_tag)
);

// File: tb/test_taint_unit.sv
module test_taint_unit;
    import taint_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic        op_ready;
    logic [2:0]  op_code;
    logic [1:0]  op_fn;
    logic [2:0]  op_rd, op_rs1, op_rs2;
    logic [15:0] op_imm;
    logic        res_valid;
    logic [15:0] res_data;
    logic        res_tag;
    logic        fault;
    logic [2:0]  fault_reg;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // bench model of architectural state
    logic [15:0] m_val  [8];
    logic        m_tag  [8];
    logic [15:0] m_mem  [64];
    logic        m_mtag [64];

    always #5 clk = ~clk;

    taint_unit i_taint_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
        .op_code(op_code), .op_fn(op_fn), .op_rd(op_rd), .op_rs1(op_rs1),
        .op_rs2(op_rs2), .op_imm(op_imm), .res_valid(res_valid),
        .res_data(res_data), .res_tag(res_tag), .fault(fault),
        .fault_reg(fault_reg)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_alu(input logic [1:0] fn,
                                            input logic [15:0] a,
                                            input logic [15:0] b);
        case (fn)
            2'd0:    return a + b;
            2'd1:    return a - b;
            2'd2:    return a ^ b;
            default: return a;
        endcase
    endfunction

    // Drive one micro-op at a falling edge, check its registered result.
    task automatic run_op(input logic [2:0] code, input logic [1:0] fn,
                          input int rd, input int rs1, input int rs2,
                          input logic [15:0] imm, input string req_in = "");
        logic [15:0] av, bv, e_data;
        logic        at, bt, e_tag, e_valid, e_fault;
        logic [5:0]  addr;
        logic [21:0] got, exp;
        string       req;
        av = m_val[rs1]; at = m_tag[rs1];
        bv = m_val[rs2]; bt = m_tag[rs2];
        addr = av[5:0];
        e_valid = 1'b0; e_fault = 1'b0; e_data = '0; e_tag = 1'b0;
        req = "R11";
        case (code)
            3'd0: begin e_valid = 1; e_data = imm; e_tag = 1;
                        m_val[rd] = imm; m_tag[rd] = 1; req = "R2"; end
            3'd1: begin e_valid = 1; e_data = imm; e_tag = 0;
                        m_val[rd] = imm; m_tag[rd] = 0; req = "R3"; end
            3'd2: begin e_valid = 1; e_data = exp_alu(fn, av, bv); e_tag = at | bt;
                        m_val[rd] = e_data; m_tag[rd] = e_tag; req = "R4"; end
            3'd3: begin e_valid = 1; e_data = {15'd0, av == bv}; e_tag = 0;
                        m_tag[rs1] = 0; req = "R9"; end
            3'd4: if (at) begin e_fault = 1; req = "R8"; end
                  else begin
                      e_valid = 1; e_data = m_mem[addr]; e_tag = m_mtag[addr];
                      m_val[rd] = e_data; m_tag[rd] = e_tag;
                      req = e_tag ? "R7" : "R5";
                  end
            3'd5: if (at) begin e_fault = 1; req = "R8"; end
                  else begin
                      e_valid = 1; e_data = bv; e_tag = bt;
                      m_mem[addr] = bv; m_mtag[addr] = bt;
                      req = bt ? "R7" : "R6";
                  end
            3'd6: if (at) begin e_fault = 1; req = "R8"; end
                  else begin e_valid = 1; e_data = av; e_tag = 0; req = "R10"; end
            default: ;
        endcase
        if (req_in != "") req = {req_in, "/", req};
        op_code = code; op_fn = fn; op_rd = 3'(rd); op_rs1 = 3'(rs1);
        op_rs2 = 3'(rs2); op_imm = imm; op_valid = 1'b1;
        @(posedge clk);
        #2;
        exp = {e_valid, e_fault, e_fault ? 3'(rs1) : 3'd0,
               e_valid ? {e_data, e_tag} : 17'd0};
        got = {res_valid, fault, e_fault ? fault_reg : 3'd0,
               e_valid ? {res_data, res_tag} : 17'd0};
        chk(got == exp, req, "{valid,fault,reg,data,tag}", 32'(got), 32'(exp));
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic read_reg(input int r, input string req = "");
        run_op(3'd2, 2'd3, r, r, 0, 16'd0, req);
    endtask

    task automatic idle_cycle(input int rd, input logic [15:0] imm);
        op_code = 3'd0; op_rd = 3'(rd); op_imm = imm; op_valid = 1'b0;
        @(posedge clk);
        #2;
        chk(!res_valid && !fault, "R12", "idle {valid,fault}",
            {30'd0, res_valid, fault}, 32'd0);
        @(negedge clk);
    endtask

    task automatic mem_word(input int a, input string req = "");
        run_op(3'd1, 2'd0, 7, 0, 0, 16'(a), req);
        run_op(3'd4, 2'd0, 6, 7, 0, 16'd0, req);
    endtask

    initial begin : watchdog
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stimulus
        void'($urandom(32'h7a17_2c05));
        for (int i = 0; i < 8; i++) begin m_val[i] = '0; m_tag[i] = 1'b0; end
        for (int i = 0; i < 64; i++) begin m_mem[i] = '0; m_mtag[i] = 1'b0; end
        rst = 1'b1; op_valid = 1'b0; op_code = '0; op_fn = '0;
        op_rd = '0; op_rs1 = '0; op_rs2 = '0; op_imm = '0;
        repeat (3) @(posedge clk);
        #2;
        chk(op_ready == 1'b0, "R12", "ready in reset", {31'd0, op_ready}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(op_ready && !res_valid && !fault, "R1",
            "{ready,valid,fault} after reset", {29'd0, op_ready, res_valid, fault}, 32'd4);
        @(negedge clk);

        // R1: all registers and a few memory words come up clear
        for (int r = 0; r < 8; r++) read_reg(r, "R1");
        run_op(3'd4, 2'd0, 1, 0, 0, 16'd0, "R1");
        run_op(3'd4, 2'd0, 1, 0, 0, 16'd0, "R1");

        // Taint entering, spreading through ALU and memory
        run_op(3'd0, 2'd0, 1, 0, 0, 16'h0025);        // R2
        run_op(3'd1, 2'd0, 2, 0, 0, 16'h0005);        // R3
        run_op(3'd2, 2'd0, 3, 1, 2, 16'd0);           // R4 add, tainted
        run_op(3'd2, 2'd1, 4, 2, 1, 16'd0);           // R4 sub wraps
        run_op(3'd2, 2'd2, 4, 2, 2, 16'd0);           // R4 xor, clean
        run_op(3'd5, 2'd0, 0, 2, 1, 16'd0);           // R7 store tainted data
        run_op(3'd4, 2'd0, 5, 2, 0, 16'd0);           // R7 load tainted data
        run_op(3'd4, 2'd0, 6, 5, 0, 16'd0);           // R8 loaded value as pointer
        read_reg(6, "R8");                            // destination untouched
        run_op(3'd5, 2'd0, 0, 3, 2, 16'd0);           // R8 ALU-derived pointer store
        mem_word(42, "R8");                           // 0x2a unchanged
        run_op(3'd6, 2'd0, 0, 1, 0, 16'd0);           // R8 jump
        run_op(3'd6, 2'd0, 0, 3, 0, 16'd0);           // R8 back-to-back fault
        run_op(3'd3, 2'd0, 0, 1, 2, 16'd0);           // R9 not equal, clears r1
        read_reg(1, "R9");
        run_op(3'd6, 2'd0, 0, 1, 0, 16'd0);           // R10 target 0x0025
        run_op(3'd4, 2'd0, 6, 1, 0, 16'd0);           // R5 now allowed
        run_op(3'd3, 2'd0, 0, 5, 5, 16'd0);           // R9 self compare equals
        read_reg(5, "R9");
        run_op(3'd0, 2'd0, 7, 0, 0, 16'h1234);
        run_op(3'd3, 2'd0, 0, 2, 7, 16'd0);           // R9 rs2 keeps its tag
        read_reg(7, "R9");
        run_op(3'd7, 2'd0, 2, 1, 1, 16'hffff);        // R11
        read_reg(2, "R11");
        idle_cycle(4, 16'hbeef);                      // R12
        read_reg(4, "R12");
        run_op(3'd1, 2'd0, 2, 0, 0, 16'hffc0 | 16'd63);
        run_op(3'd5, 2'd0, 0, 2, 7, 16'd0);           // R6 high bits ignored, word 63
        mem_word(63, "R6");

        // Seeded random mix
        for (int n = 0; n < 1500; n++) begin
            logic [2:0] c;
            c = 3'($urandom % 8);
            run_op(c, 2'($urandom), int'($urandom % 8), int'($urandom % 8),
                   int'($urandom % 8), 16'($urandom));
            if (($urandom % 10) == 0) idle_cycle(int'($urandom % 8), 16'($urandom));
        end

        // Sweep all state
        for (int r = 0; r < 8; r++) read_reg(r, "R4");
        for (int a = 0; a < 64; a++) mem_word(a, "R6");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule